// File: doc/BRIEF.md
# External Interrupt Sense Unit

This block conditions external interrupt sources before they reach a parent interrupt controller. The parent accepts only two kinds of input: an active-high level or a rising edge. Sixteen external pins and one system error input each have a programmable 2-bit sense mode. The four modes are low level, falling edge, rising edge and both edges. Whatever the mode, the unit turns the source into one of the two forms the parent accepts. A source in low-level mode comes out as an active-high level. A source in any edge mode comes out as a single-cycle high pulse.

Sixteen software trigger lines also pass through the unit. They have no mode field and are always detected on their rising edge. Every source, whether a pin, the error input or a trigger line, goes through a two-flop synchronizer and one detection register. The latency from input to output is therefore three clocks for all of them.

The mode fields live in two register banks, each holding one 32-bit mode word at offset 0xC. The general bank holds pins 0 to 13. The protected bank holds pins 14 and 15 and the error input. A small read/write port with a per-bit write mask gives access to both banks. Masking, priority and end-of-interrupt handling are left to the parent controller.

Top module: `irqsense_unit`

## Requirements
- R1: After reset every mode field holds 10 (rising edge). The mode word therefore reads 0x0AAAAAAA in the general bank (bus_bank=0) and 0x0000002A in the protected bank (bus_bank=1), and all outputs are low while the inputs are low. Any address other than 0xC reads zero, and writes to such an address change nothing.
- R2: A write to offset 0xC changes only the bits whose bus_wmask bit is 1. Bits above the last field of a bank always read 0.
- R3: The field for pin i (i = 0..13) sits at bits [2i+1:2i] of the general bank. Pins 14 and 15 use bits [1:0] and [3:2] of the protected bank, and the error input uses bits [5:4] of the protected bank. A write to one bank leaves the other bank unchanged.
- R4: In mode 00 (low level), the output is high exactly while the input was low three clocks earlier.
- R5: In mode 01 (falling edge), each high-to-low input transition gives a one-cycle output pulse, three clocks later.
- R6: In mode 10 (rising edge), each low-to-high input transition gives a one-cycle output pulse, three clocks later.
- R7: In mode 11 (both edges), each input transition in either direction gives a one-cycle pulse, three clocks later. In any edge mode, a steady input gives no pulse.
- R8: Each software trigger line gives a one-cycle pulse three clocks after each low-to-high transition, and nothing on a falling transition.
- R9: On the clock after a write that changes a source's field, that source's edge output stays low, even if its synchronized input changes at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 16 | External interrupt pins, asynchronous |
| syserr_i | input | 1 | System error input, asynchronous |
| soft_i | input | 16 | Software trigger lines |
| bus_we | input | 1 | Register write strobe |
| bus_bank | input | 1 | Bank select: 0 general, 1 protected |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_wmask | input | 32 | Per-bit write enable |
| bus_rdata | output | 32 | Read data, combinational from bank and address |
| pin_o | output | 16 | Normalized pin outputs |
| syserr_o | output | 1 | Normalized error output |
| soft_o | output | 16 | Software trigger pulses |

## Verification
The bench uses the default parameters: 14 general pins, 2 protected pins, 16 trigger lines and a two-stage synchronizer. This gives 17 selectable sources across both banks, few enough that a rotating assignment puts every source through all four modes in four phases. In each phase the bench drives random input patterns and compares every output on every cycle against a bench-side history model of the three-clock path. Directed steps cover the reset words, masked and out-of-range writes, bank isolation, and a mode change timed to land on a synchronized edge.

// File: rtl/irqsense_pkg.sv
package irqsense_pkg;
  localparam int REG_W = 32;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_FALL = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_t;

  // Normalized event for one synchronized sample and the sample before it.
  function automatic logic sense_eval(sense_t m, logic cur, logic prv);
    logic r;
    unique case (m)
      SENSE_LOW:  r = ~cur;
      SENSE_FALL: r = prv & ~cur;
      SENSE_RISE: r = cur & ~prv;
      default:    r = cur ^ prv;
    endcase
    return r;
  endfunction

  // Replicates one mode into n two-bit fields.
  function automatic logic [REG_W-1:0] fill_fields(sense_t m, int unsigned n);
    logic [REG_W-1:0] v;
    v = '0;
    for (int unsigned i = 0; i < n; i++) v[2*i+:2] = m;
    return v;
  endfunction
endpackage

// File: rtl/irqsense_cell.sv
module irqsense_cell
  import irqsense_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   raw_i,
  input  sense_t mode_i,
  input  logic   realign_i,
  output logic   sync_o,
  output logic   evt_o
);
  logic [SYNC_STAGES-1:0] chain_q;
  logic                   prv_q;
  logic                   evt_q;
  logic                   cur;

  assign cur = chain_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prv_q   <= 1'b0;
      evt_q   <= 1'b0;
    end else begin
      chain_q <= {chain_q[SYNC_STAGES-2:0], raw_i};
      prv_q   <= cur;
      if (realign_i && mode_i != SENSE_LOW) evt_q <= 1'b0;
      else                                  evt_q <= sense_eval(mode_i, cur, prv_q);
    end
  end

  assign sync_o = cur;
  assign evt_o  = evt_q;
endmodule

// File: rtl/irqsense_bank.sv
module irqsense_bank
  import irqsense_pkg::*;
#(
  parameter int          NF        = 14,
  parameter int          ADDR_W    = 8,
  parameter logic [7:0]  MODE_ADDR = 8'h0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [REG_W-1:0]  wmask_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic [2*NF-1:0]   fields_o,
  output logic [NF-1:0]     chg_o
);
  localparam int FW = 2 * NF;
  localparam logic [FW-1:0] RST_VAL = FW'(fill_fields(SENSE_RISE, NF));

  logic [FW-1:0] fields_q, nxt;
  logic [NF-1:0] chg_q, chg_d;
  logic          hit;

  assign hit = we_i && (addr_i == ADDR_W'(MODE_ADDR));
  assign nxt = (fields_q & ~wmask_i[FW-1:0]) | (wdata_i[FW-1:0] & wmask_i[FW-1:0]);

  for (genvar f = 0; f < NF; f++) begin : g_chg
    assign chg_d[f] = hit && (nxt[2*f+:2] != fields_q[2*f+:2]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fields_q <= RST_VAL;
      chg_q    <= '0;
    end else begin
      if (hit) fields_q <= nxt;
      chg_q <= chg_d;
    end
  end

  assign rdata_o  = (addr_i == ADDR_W'(MODE_ADDR)) ? REG_W'(fields_q) : '0;
  assign fields_o = fields_q;
  assign chg_o    = chg_q;
endmodule

// File: rtl/irqsense_unit.sv
module irqsense_unit
  import irqsense_pkg::*;
#(
  parameter int         NS_PINS     = 14,
  parameter int         S_PINS      = 2,
  parameter int         SOFT_LINES  = 16,
  parameter int         SYNC_STAGES = 2,
  parameter int         ADDR_W      = 8,
  parameter logic [7:0] MODE_ADDR   = 8'h0C
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NS_PINS+S_PINS-1:0] pin_i,
  input  logic                      syserr_i,
  input  logic [SOFT_LINES-1:0]     soft_i,
  input  logic                      bus_we,
  input  logic                      bus_bank,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [31:0]               bus_wdata,
  input  logic [31:0]               bus_wmask,
  output logic [31:0]               bus_rdata,
  output logic [NS_PINS+S_PINS-1:0] pin_o,
  output logic                      syserr_o,
  output logic [SOFT_LINES-1:0]     soft_o
);
  localparam int NPIN     = NS_PINS + S_PINS;
  localparam int S_FIELDS = S_PINS + 1;
  localparam int NSRC     = NPIN + 1;

  logic [2*NS_PINS-1:0]  ns_fields;
  logic [2*S_FIELDS-1:0] s_fields;
  logic [NS_PINS-1:0]    ns_chg;
  logic [S_FIELDS-1:0]   s_chg;
  logic [REG_W-1:0]      ns_rdata, s_rdata;

  // Named internal events, visible to the bound checker.
  logic [2*NSRC-1:0]     src_mode;
  logic [NSRC-1:0]       src_chg, src_raw, src_sync, src_evt;
  logic [SOFT_LINES-1:0] soft_sync, soft_evt;

  irqsense_bank #(.NF(NS_PINS), .ADDR_W(ADDR_W), .MODE_ADDR(MODE_ADDR)) u_bank_gen (
    .clk(clk), .rst_n(rst_n), .we_i(bus_we & ~bus_bank), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .wmask_i(bus_wmask), .rdata_o(ns_rdata),
    .fields_o(ns_fields), .chg_o(ns_chg)
  );

  irqsense_bank #(.NF(S_FIELDS), .ADDR_W(ADDR_W), .MODE_ADDR(MODE_ADDR)) u_bank_prot (
    .clk(clk), .rst_n(rst_n), .we_i(bus_we & bus_bank), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .wmask_i(bus_wmask), .rdata_o(s_rdata),
    .fields_o(s_fields), .chg_o(s_chg)
  );

  // Source order: general pins, protected pins, then the error input.
  assign src_mode = {s_fields, ns_fields};
  assign src_chg  = {s_chg, ns_chg};
  assign src_raw  = {syserr_i, pin_i};

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    irqsense_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
      .clk(clk), .rst_n(rst_n), .raw_i(src_raw[g]),
      .mode_i(sense_t'(src_mode[2*g+:2])), .realign_i(src_chg[g]),
      .sync_o(src_sync[g]), .evt_o(src_evt[g])
    );
  end

  for (genvar g = 0; g < SOFT_LINES; g++) begin : g_soft
    irqsense_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
      .clk(clk), .rst_n(rst_n), .raw_i(soft_i[g]),
      .mode_i(SENSE_RISE), .realign_i(1'b0),
      .sync_o(soft_sync[g]), .evt_o(soft_evt[g])
    );
  end

  assign pin_o     = src_evt[NPIN-1:0];
  assign syserr_o  = src_evt[NPIN];
  assign soft_o    = soft_evt;
  assign bus_rdata = bus_bank ? s_rdata : ns_rdata;
endmodule

// File: rtl/irqsense_unit_chk.sv
module irqsense_unit_chk #(
  parameter int         NS_PINS    = 14,
  parameter int         S_PINS     = 2,
  parameter int         SOFT_LINES = 16,
  parameter int         ADDR_W     = 8,
  parameter logic [7:0] MODE_ADDR  = 8'h0C
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic                                bus_we,
  input logic                                bus_bank,
  input logic [ADDR_W-1:0]                   bus_addr,
  input logic [31:0]                         bus_rdata,
  input logic [2*NS_PINS-1:0]                ns_fields,
  input logic [2*(S_PINS+1)-1:0]             s_fields,
  input logic [2*(NS_PINS+S_PINS+1)-1:0]     src_mode,
  input logic [NS_PINS+S_PINS:0]             src_chg,
  input logic [NS_PINS+S_PINS:0]             src_sync,
  input logic [NS_PINS+S_PINS:0]             src_evt,
  input logic [SOFT_LINES-1:0]               soft_sync,
  input logic [SOFT_LINES-1:0]               soft_evt
);
  localparam int NSRC = NS_PINS + S_PINS + 1;

  assert_unmapped_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != ADDR_W'(MODE_ADDR)) |-> (bus_rdata == '0));

  assert_prot_isolated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_bank) |=> $stable(ns_fields));

  assert_gen_isolated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !bus_bank) |=> $stable(s_fields));

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assert_low_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (src_mode[2*g+:2] == 2'b00) |=> (src_evt[g] == !$past(src_sync[g])));

    assert_fall_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (src_mode[2*g+:2] == 2'b01 && !src_chg[g] && $fell(src_sync[g])) |=> src_evt[g]);

    assert_rise_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (src_mode[2*g+:2] == 2'b10 && !src_chg[g] && $rose(src_sync[g])) |=> src_evt[g]);

    assert_both_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (src_mode[2*g+:2] == 2'b11 && !src_chg[g] &&
       ($rose(src_sync[g]) || $fell(src_sync[g]))) |=> src_evt[g]);

    assert_steady_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (src_mode[2*g+:2] != 2'b00 && $stable(src_sync[g])) |=> !src_evt[g]);

    assert_realign_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (src_chg[g] && src_mode[2*g+:2] != 2'b00) |=> !src_evt[g]);
  end

  for (genvar g = 0; g < SOFT_LINES; g++) begin : g_soft
    assert_soft_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(soft_sync[g]) |=> soft_evt[g]);

    assert_soft_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      soft_evt[g] |=> !soft_evt[g]);
  end
endmodule

bind irqsense_unit irqsense_unit_chk #(
  .NS_PINS(NS_PINS), .S_PINS(S_PINS), .SOFT_LINES(SOFT_LINES),
  .ADDR_W(ADDR_W), .MODE_ADDR(MODE_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_bank(bus_bank),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .ns_fields(ns_fields),
  .s_fields(s_fields), .src_mode(src_mode), .src_chg(src_chg),
  .src_sync(src_sync), .src_evt(src_evt), .soft_sync(soft_sync),
  .soft_evt(soft_evt)
);

// File: tb/irqsense_unit_test.sv
module irqsense_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] pin_i;
  logic        syserr_i;
  logic [15:0] soft_i;
  logic        bus_we, bus_bank;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_wmask, bus_rdata;
  logic [15:0] pin_o;
  logic        syserr_o;
  logic [15:0] soft_o;

  int nvec = 0;
  int nbad = 0;

  logic [16:0] hist  [4];
  logic [15:0] shist [4];
  logic [1:0]  mode_b [17];

  always #(CLK_PERIOD/2) clk = ~clk;

  irqsense_unit uut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .syserr_i(syserr_i), .soft_i(soft_i),
    .bus_we(bus_we), .bus_bank(bus_bank), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wmask(bus_wmask), .bus_rdata(bus_rdata),
    .pin_o(pin_o), .syserr_o(syserr_o), .soft_o(soft_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Expected output from the sample three clocks back (cur) and four back (prv).
  function automatic logic model(input logic [1:0] m, input logic cur, input logic prv);
    case (m)
      2'b00:   return !cur;
      2'b01:   return prv && !cur;
      2'b10:   return cur && !prv;
      default: return cur != prv;
    endcase
  endfunction

  function automatic string req_of(input logic [1:0] m);
    case (m)
      2'b00:   return "R4";
      2'b01:   return "R5";
      2'b10:   return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic step(input logic [15:0] p, input logic s, input logic [15:0] sw, input bit chk);
    @(negedge clk);
    if (chk) begin
      for (int j = 0; j < 17; j++) begin
        logic act;
        act = (j < 16) ? pin_o[j] : syserr_o;
        check(req_of(mode_b[j]), 32'(act), 32'(model(mode_b[j], hist[2][j], hist[3][j])),
              $sformatf("source %0d", j));
      end
      for (int j = 0; j < 16; j++)
        check("R8", 32'(soft_o[j]), 32'(model(2'b10, shist[2][j], shist[3][j])),
              $sformatf("soft line %0d", j));
    end
    for (int k = 3; k > 0; k--) begin
      hist[k]  = hist[k-1];
      shist[k] = shist[k-1];
    end
    hist[0]  = {s, p};
    shist[0] = sw;
    pin_i    = p;
    syserr_i = s;
    soft_i   = sw;
  endtask

  task automatic wr(input logic b, input logic [7:0] a, input logic [31:0] d, input logic [31:0] m);
    @(negedge clk);
    bus_we = 1'b1; bus_bank = b; bus_addr = a; bus_wdata = d; bus_wmask = m;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic b, input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_bank = b; bus_addr = a;
    #1;
    check(req, bus_rdata, exp, $sformatf("read bank %0d offset %h", b, a));
  endtask

  initial begin
    rst_n = 1'b0; pin_i = '0; syserr_i = 1'b0; soft_i = '0;
    bus_we = 1'b0; bus_bank = 1'b0; bus_addr = 8'h0C; bus_wdata = '0; bus_wmask = '0;
    for (int k = 0; k < 4; k++) begin hist[k] = '0; shist[k] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset words, idle outputs, unmapped offsets
    @(negedge clk);
    check("R1", {15'd0, syserr_o, pin_o}, 32'd0, "outputs after reset");
    check("R1", {16'd0, soft_o}, 32'd0, "soft outputs after reset");
    rd(1'b0, 8'h0C, 32'h0AAAAAAA, "R1");
    rd(1'b1, 8'h0C, 32'h0000002A, "R1");
    rd(1'b0, 8'h08, 32'h0, "R1");
    wr(1'b0, 8'h10, 32'hFFFFFFFF, 32'hFFFFFFFF);
    rd(1'b0, 8'h0C, 32'h0AAAAAAA, "R1");

    // R2: masked field write and unused upper bits
    wr(1'b0, 8'h0C, 32'h0, 32'h0000000C);
    rd(1'b0, 8'h0C, 32'h0AAAAAA2, "R2");
    wr(1'b0, 8'h0C, 32'hFFFFFFFF, 32'hF0000000);
    rd(1'b0, 8'h0C, 32'h0AAAAAA2, "R2");

    // R3: protected bank write leaves general bank; protected sources follow it
    wr(1'b1, 8'h0C, 32'h0, 32'hFFFFFFFF);
    rd(1'b0, 8'h0C, 32'h0AAAAAA2, "R3");
    rd(1'b1, 8'h0C, 32'h0, "R3");
    repeat (4) @(negedge clk);
    check("R3", {28'd0, syserr_o, pin_o[15:13]}, 32'hE, "low-level on protected sources only");

    // R4..R8 and R3 mapping: every source through every mode by rotation
    for (int k = 0; k < 4; k++) begin
      logic [31:0] nsw, psw;
      nsw = '0; psw = '0;
      for (int j = 0; j < 17; j++) begin
        mode_b[j] = 2'((j + k) % 4);
        if (j < 14) nsw[2*j+:2] = mode_b[j];
        else        psw[2*(j-14)+:2] = mode_b[j];
      end
      wr(1'b0, 8'h0C, nsw, 32'hFFFFFFFF);
      wr(1'b1, 8'h0C, psw, 32'hFFFFFFFF);
      rd(1'b0, 8'h0C, nsw, "R3");
      rd(1'b1, 8'h0C, psw, "R3");
      repeat (5) step(pin_i, syserr_i, soft_i, 1'b0);
      repeat (50) step(16'($urandom), 1'($urandom), 16'($urandom), 1'b1);
    end

    // R9: pin 0 falling -> rising, change lands as the synchronized rise arrives
    wr(1'b0, 8'h0C, 32'h1, 32'h3);
    repeat (5) step(16'h0, 1'b0, 16'h0, 1'b0);
    step(16'h1, 1'b0, 16'h0, 1'b0);
    wr(1'b0, 8'h0C, 32'h2, 32'h3);
    for (int c = 0; c < 6; c++) begin
      check("R9", 32'(pin_o[0]), 32'd0, $sformatf("pin 0 after mode change, cycle %0d", c));
      @(negedge clk);
    end
    // R6: a later genuine rise on pin 0 still pulses
    mode_b[0] = 2'b10;
    repeat (5) step(16'h1, 1'b0, 16'h0, 1'b0);
    repeat (2) step(16'h0, 1'b0, 16'h0, 1'b1);
    repeat (6) step(16'h1, 1'b0, 16'h0, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule